// File: doc/BRIEF.md
# Dual-Group Manchester Packet Transmitter

This block builds numbered packets and sends them as Manchester-coded serial streams on eight line outputs. The outputs form two groups of four lines. All four lines in a group carry the same waveform. Both groups take their packet number from one shared sequence input. Each group has its own spacing value, which sets the idle time between packets. The block runs on a clock at twice the bit rate, so each half of a Manchester bit lasts one clock period. At a 100 MHz clock the line rate is 50 MHz.

A packet has 40 bits. It starts with the 8-bit marker 0xA5, followed by the 32-bit sequence number, most significant bit first. Each group captures the sequence number and its own spacing value in the cycle it starts a packet. After the packet ends, the group holds its lines low for the captured number of idle bit times and then starts the next packet. A spacing of zero gives back-to-back packets. A new spacing value therefore applies from the next packet boundary.

Top module: `mtx_top`

## Requirements
- R1: While `rst_n` is low, all eight lines are low.
- R2: Each bit lasts two clock cycles. A 1 is sent as high then low, and a 0 as low then high, so the two halves of every bit are complementary.
- R3: A packet is 40 bits: the marker 0xA5, then the 32-bit sequence number, most significant bit first.
- R4: The sequence number sent in a packet is the value of `seq_num_i` on the rising edge before the packet's first half-bit appears. Later changes to `seq_num_i` do not alter a packet already started.
- R5: Between packets the lines stay low for exactly 2*S clock cycles, where S is the spacing in effect for that group. With S = 0, the next packet's first half-bit directly follows the previous packet's last half-bit.
- R6: The spacing used after a packet is the group's spacing input sampled on the same edge as that packet's sequence number. Changes during a packet or during a gap take effect only at the next packet start.
- R7: Lines 3..0 form group A and follow `spacing_a_i`. Lines 7..4 form group B and follow `spacing_b_i`. The four lines of a group are always identical.
- R8: The two groups are independent. One group's spacing has no effect on the other group's waveform.
- R9: After `rst_n` rises, each group's first half-bit appears on the fourth rising clock edge. Two edges synchronise the reset release, one loads the packet, and one registers the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the line bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_num_i | input | 32 | Sequence number captured at each packet start |
| spacing_a_i | input | 8 | Idle bit times between packets of group A |
| spacing_b_i | input | 8 | Idle bit times between packets of group B |
| lines_o | output | 8 | Manchester line outputs; [3:0] group A, [7:4] group B |

## Verification
The hardest behaviour to reach from the ports is deferred capture. A spacing or sequence value that changes while a packet or gap is in flight must not affect that packet or gap.

The stimulus therefore advances `seq_num_i` every cycle and rewrites both spacing values every 17 cycles, so new values arrive in the middle of packets and gaps. The scoreboard records the inputs seen on the load edge. It then requires the decoded packet and the following idle length to match those recorded values. The stimulus also covers a zero spacing, the maximum spacing, sequence wrap-around and a reset in the middle of a packet.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic {
    ST_GAP  = 1'b0,
    ST_SEND = 1'b1
  } mtx_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mtx_rst_sync.sv
module mtx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync_o = sync_q;

endmodule

// File: rtl/mtx_framer.sv
module mtx_framer #(
  parameter int unsigned SEQ_W = 32,
  parameter int unsigned PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hA5,
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             bit_o,
  output logic             act_o,
  output logic             second_o
);

  import mtx_pkg::*;

  localparam int unsigned PKT_W  = PRE_W + SEQ_W;
  localparam int unsigned HALVES = 2 * PKT_W;
  localparam int unsigned CNT_W  = max_u($clog2(HALVES), GAP_W + 1);

  mtx_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PKT_W-1:0] shreg_q, shreg_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cnt_zero;
  logic             load_en;
  logic             shift_en;

  assign cnt_zero = (cnt_q == '0);
  assign load_en  = cnt_zero && ((state_q == ST_GAP) || (gap_q == '0));
  assign shift_en = (state_q == ST_SEND) && !cnt_q[0];

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    gap_d   = gap_q;
    if (load_en) begin
      state_d = ST_SEND;
      cnt_d   = CNT_W'(HALVES - 1);
      shreg_d = {PREAMBLE, seq_i};
      gap_d   = gap_i;
    end else if (state_q == ST_SEND) begin
      if (shift_en) begin
        shreg_d = {shreg_q[PKT_W-2:0], 1'b0};
      end
      if (cnt_zero) begin
        state_d = ST_GAP;
        cnt_d   = CNT_W'({gap_q, 1'b0}) - CNT_W'(1);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GAP;
      cnt_q   <= '0;
      shreg_q <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      gap_q   <= gap_d;
    end
  end

  assign act_o    = (state_q == ST_SEND);
  assign bit_o    = shreg_q[PKT_W-1];
  assign second_o = !cnt_q[0];

endmodule

// File: rtl/mtx_line_enc.sv
module mtx_line_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic bit_i,
  input  logic second_i,
  output logic line_o
);

  logic line_q, line_d;

  always_comb begin
    line_d = act_i & (bit_i ^ second_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else begin
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/mtx_top.sv
module mtx_top #(
  parameter int unsigned SEQ_W = 32,
  parameter int unsigned PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hA5,
  parameter int unsigned GAP_W = 8,
  parameter int unsigned LINES_PER_GRP = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SEQ_W-1:0]             seq_num_i,
  input  logic [GAP_W-1:0]             spacing_a_i,
  input  logic [GAP_W-1:0]             spacing_b_i,
  output logic [2*LINES_PER_GRP-1:0]   lines_o
);

  localparam int unsigned GROUPS = 2;

  logic              rst_n_int;
  logic [GAP_W-1:0]  gap_sel [GROUPS];
  logic [GROUPS-1:0] grp_act;
  logic [GROUPS-1:0] grp_second;
  logic [GROUPS-1:0] grp_bit;
  logic [GROUPS-1:0] grp_line;

  assign gap_sel[0] = spacing_a_i;
  assign gap_sel[1] = spacing_b_i;

  mtx_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    mtx_framer #(
      .SEQ_W    (SEQ_W),
      .PRE_W    (PRE_W),
      .PREAMBLE (PREAMBLE),
      .GAP_W    (GAP_W)
    ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .seq_i    (seq_num_i),
      .gap_i    (gap_sel[g]),
      .bit_o    (grp_bit[g]),
      .act_o    (grp_act[g]),
      .second_o (grp_second[g])
    );

    mtx_line_enc u_enc (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .act_i    (grp_act[g]),
      .bit_i    (grp_bit[g]),
      .second_i (grp_second[g]),
      .line_o   (grp_line[g])
    );

    assign lines_o[g*LINES_PER_GRP +: LINES_PER_GRP] = {LINES_PER_GRP{grp_line[g]}};
  end

endmodule

// File: rtl/mtx_top_chk.sv
module mtx_top_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] lines,
  input logic [1:0] act,
  input logic [1:0] second
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (lines == 8'h00));

  // R7
  grp_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lines[3:0] == 4'h0) || (lines[3:0] == 4'hF)) &&
    ((lines[7:4] == 4'h0) || (lines[7:4] == 4'hF)));

  // R2
  half_flip_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && second[0]) |=> (lines[0] != $past(lines[0])));

  // R2
  half_flip_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act[1] && second[1]) |=> (lines[4] != $past(lines[4])));

  // R5
  idle_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act[0] |=> (lines[0] == 1'b0));

  // R5
  idle_low_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act[1] |=> (lines[4] == 1'b0));

endmodule

bind mtx_top mtx_top_chk u_mtx_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .lines  (lines_o),
  .act    (grp_act),
  .second (grp_second)
);

// File: tb/tb_mtx_top.sv
module tb_mtx_top;

  typedef struct packed {
    logic [31:0] seq;
    logic [7:0]  gap;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] seq_num_i;
  logic [7:0]  spacing_a_i;
  logic [7:0]  spacing_b_i;
  logic [7:0]  lines_o;

  int vecs;
  int fails;
  bit wd_fail;
  bit end_req;
  bit end_done;

  mtx_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_num_i   (seq_num_i),
    .spacing_a_i (spacing_a_i),
    .spacing_b_i (spacing_b_i),
    .lines_o     (lines_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard state, one slot per group
  item_t       qa[$];
  item_t       qb[$];
  int          mode   [2];
  int          hcnt   [2];
  int          idle   [2];
  int          npkt   [2];
  bit          started[2];
  logic        h1     [2];
  logic [39:0] sh     [2];
  logic [7:0]  expgap [2];
  logic [31:0] seq_prev;
  logic [7:0]  gap_prev [2];
  int          rel_cnt;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      // R1
      chk(lines_o == 8'h00, "R1", 64'(lines_o), 64'h0);
      rel_cnt = 0;
      qa.delete();
      qb.delete();
      for (int g = 0; g < 2; g++) begin
        mode[g] = 0; hcnt[g] = 0; idle[g] = 0; started[g] = 0;
      end
    end else begin
      rel_cnt++;
      for (int g = 0; g < 2; g++) begin
        logic [3:0] grp;
        logic       l;
        grp = lines_o[g*4 +: 4];
        l   = grp[0];
        // R7
        if (!((grp == 4'h0) || (grp == 4'hF)))
          chk(1'b0, "R7", 64'(grp), 64'(l ? 4'hF : 4'h0));
        if (mode[g] == 0) begin
          if (l) begin
            if (started[g]) begin
              // R5 R6 R8: idle length follows this group's own captured spacing
              chk(idle[g] == 2 * int'(expgap[g]), "R5/R6", 64'(idle[g]), 64'(2 * int'(expgap[g])));
            end else begin
              // R9
              chk(rel_cnt == 4, "R9", 64'(rel_cnt), 64'd4);
            end
            started[g] = 1;
            if (g == 0) qa.push_back({seq_prev, gap_prev[0]});
            else        qb.push_back({seq_prev, gap_prev[1]});
            mode[g] = 1;
            hcnt[g] = 1;
            h1[g]   = l;
          end else begin
            idle[g]++;
          end
        end else begin
          if (hcnt[g] % 2 == 0) begin
            h1[g] = l;
          end else begin
            // R2
            if (l == h1[g]) chk(1'b0, "R2", 64'(l), 64'(!h1[g]));
            sh[g] = {sh[g][38:0], h1[g]};
          end
          hcnt[g]++;
          if (hcnt[g] == 80) begin
            item_t it;
            if (g == 0) it = qa.pop_front();
            else        it = qb.pop_front();
            // R3
            chk(sh[g][39:32] == 8'hA5, "R3", 64'(sh[g][39:32]), 64'hA5);
            // R4
            chk(sh[g][31:0] == it.seq, "R4", 64'(sh[g][31:0]), 64'(it.seq));
            expgap[g] = it.gap;
            npkt[g]++;
            mode[g] = 0;
            idle[g] = 0;
          end
        end
      end
    end
    seq_prev    = seq_num_i;
    gap_prev[0] = spacing_a_i;
    gap_prev[1] = spacing_b_i;
    if (end_req && !end_done) begin
      // R8: both groups kept producing packets under their own spacing
      chk(npkt[0] >= 40, "R8 group A packets", 64'(npkt[0]), 64'd40);
      chk(npkt[1] >= 40, "R8 group B packets", 64'(npkt[1]), 64'd40);
      end_done = 1;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs + (wd_fail ? 1 : 0), fails + (wd_fail ? 1 : 0));
    $finish;
  endtask

  // sequence source advances every cycle (R4 capture check)
  initial begin
    seq_num_i = 32'hFFFF_FF00;
    forever begin
      @(negedge clk);
      seq_num_i = seq_num_i + 32'd1;
    end
  end

  initial begin
    rst_n       = 1'b0;
    spacing_a_i = 8'd3;
    spacing_b_i = 8'd0;
    npkt[0] = 0;
    npkt[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (1500) @(negedge clk);
    for (int k = 0; k < 180; k++) begin
      spacing_a_i = 8'((k * 7) % 20);
      spacing_b_i = 8'((k * 11) % 13);
      repeat (17) @(negedge clk);
    end
    // reset in the middle of traffic, then maximum spacing on group A
    rst_n = 1'b0;
    spacing_a_i = 8'd255;
    spacing_b_i = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2500) @(negedge clk);
    end_req = 1;
    repeat (3) @(negedge clk);
    report();
  end

  initial begin
    #(200000 * 4);
    wd_fail = 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

endmodule